// File: doc/BRIEF.md
# Open-Drain Two-Wire Bus Bit Engine

This block is the bit-level layer of a two-wire serial bus master. A higher-level sequencer hands it one byte-level command at a time: a start condition, a stop condition, a byte write, a byte read that ends with a chosen acknowledge level, or a bus-recovery burst. The engine then works the two open-drain lines. It only ever pulls a line low or lets it float. When the command is finished it reports the acknowledge level the slave returned after a write, or the byte it received during a read.

Every bit on the bus is split into four equal quarters. The length of one quarter is set by the parameter `DIV`, counted in system clocks. Each command asserts `done` for one cycle when it ends. The engine accepts a new command only while it is idle. The data line is read through a synchroniser before the engine samples it. There is no clock stretching, arbitration or slave operation.

Top module: `i2c_bit_master`

## Requirements
- R1: After reset both lines are released (`scl_oe`=0, `sda_oe`=0), `cmd_ready` is 1 and `done` is 0. While no command runs, neither line changes.
- R2: Command code 0 (start) spends one quarter with no line change. It then releases SDA, then releases SCL, then pulls SDA low while SCL is released, with one quarter between steps.
- R3: Command code 1 (stop) pulls SCL low, then pulls SDA low, then releases SCL, then releases SDA while SCL is high, one quarter per step. It ends with SDA released.
- R4: Command code 2 (write) sends `cmd_data` MSB first. Each bit pulls SCL low for one quarter, drives SDA to the bit in the next quarter, and holds SCL released for the last two quarters.
- R5: After the eighth bit of a write, the engine releases SDA and clocks a ninth bit. It samples SDA at the end of that bit and reports the level on `rx_nack` (0 = acknowledged, 1 = not acknowledged).
- R6: Command code 3 (read) releases SDA and clocks 8 bits. It samples SDA one quarter after SCL is released and assembles the samples MSB first on `rx_data`.
- R7: After the eight read bits, the engine drives SDA to `cmd_ack` in the quarter after SCL falls, then holds SCL high for two quarters. `cmd_ack` 0 continues the read and 1 ends it.
- R8: Command code 4 (recover) gives nine SCL pulses with SDA released throughout. Each pulse is low for two quarters and high for two quarters. A stop sequence as in R3 follows.
- R9: A command accepted at a clock edge changes the lines at that edge. Each quarter lasts `DIV` cycles. `done` is high for exactly one cycle, which starts 4·`DIV`·(bit count) cycles after the accepting edge. The bit count is 1 for start and stop, 9 for write and read, and 10 for recover. `cmd_ready` is 0 from the accepting edge until `done` rises.
- R10: A `cmd_valid` presented while a command is running is ignored. The running sequence and its result are unchanged.
- R11: Command codes 5 to 7 are accepted and complete after one bit time with no line change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Engine idle, command accepted when valid |
| cmd_op | input | 3 | Command code |
| cmd_data | input | 8 | Byte to write |
| cmd_ack | input | 1 | Acknowledge level sent after a read byte |
| done | output | 1 | One-cycle completion pulse |
| rx_data | output | 8 | Byte received by the last read |
| rx_nack | output | 1 | Acknowledge level sampled after the last write |
| sda_in | input | 1 | Data line level as seen on the bus |
| scl_oe | output | 1 | 1 pulls the clock line low |
| sda_oe | output | 1 | 1 pulls the data line low |

## Verification
Two results come from levels that another device drives on the data line: the slave's acknowledge after a write and the bits of a read. These are hard to reach from the ports. The bench therefore contains a slave model that counts falling edges of the clock line since each command was issued. It pulls the data line low for chosen bits, so both acknowledge levels and bytes with mixed bit patterns can be checked. It does this after a repeated start, without any stop in between. A second command is also presented in the middle of a running one, and the cycle-exact line model shows that nothing changes.

// File: rtl/i2c_bit_pkg.sv
package i2c_bit_pkg;

    localparam logic [2:0] OP_START   = 3'd0;
    localparam logic [2:0] OP_STOP    = 3'd1;
    localparam logic [2:0] OP_WRITE   = 3'd2;
    localparam logic [2:0] OP_READ    = 3'd3;
    localparam logic [2:0] OP_RECOVER = 3'd4;

    localparam int BYTE_BITS      = 8;
    localparam int RECOVER_PULSES = 9;
    localparam int IDX_W          = 4;

    typedef enum logic [2:0] {
        K_NOP, K_START, K_STOP, K_WBIT, K_WACK, K_RBIT, K_SACK, K_PULSE
    } bit_kind_e;

    typedef struct packed {
        logic scl_we;
        logic scl_rel;
        logic sda_we;
        logic sda_rel;
    } line_act_t;

    function automatic logic [IDX_W-1:0] last_bit(input logic [2:0] op);
        case (op)
            OP_WRITE, OP_READ: last_bit = IDX_W'(BYTE_BITS);
            OP_RECOVER:        last_bit = IDX_W'(RECOVER_PULSES);
            default:           last_bit = '0;
        endcase
    endfunction

    function automatic bit_kind_e kind_of(input logic [2:0] op, input logic [IDX_W-1:0] idx);
        case (op)
            OP_START:   kind_of = K_START;
            OP_STOP:    kind_of = K_STOP;
            OP_WRITE:   kind_of = (idx < IDX_W'(BYTE_BITS)) ? K_WBIT : K_WACK;
            OP_READ:    kind_of = (idx < IDX_W'(BYTE_BITS)) ? K_RBIT : K_SACK;
            OP_RECOVER: kind_of = (idx < IDX_W'(RECOVER_PULSES)) ? K_PULSE : K_STOP;
            default:    kind_of = K_NOP;
        endcase
    endfunction

    // Action applied when quarter q of a bit of the given kind begins.
    function automatic line_act_t act_of(input bit_kind_e kind, input logic [1:0] q,
                                         input logic dbit);
        line_act_t a;
        a = '0;
        case (kind)
            K_START: begin
                if (q == 2'd1) begin a.sda_we = 1'b1; a.sda_rel = 1'b1; end
                if (q == 2'd2) begin a.scl_we = 1'b1; a.scl_rel = 1'b1; end
                if (q == 2'd3) begin a.sda_we = 1'b1; a.sda_rel = 1'b0; end
            end
            K_STOP: begin
                if (q == 2'd0) begin a.scl_we = 1'b1; a.scl_rel = 1'b0; end
                if (q == 2'd1) begin a.sda_we = 1'b1; a.sda_rel = 1'b0; end
                if (q == 2'd2) begin a.scl_we = 1'b1; a.scl_rel = 1'b1; end
                if (q == 2'd3) begin a.sda_we = 1'b1; a.sda_rel = 1'b1; end
            end
            K_WBIT, K_SACK, K_WACK, K_RBIT, K_PULSE: begin
                if (q == 2'd0) begin a.scl_we = 1'b1; a.scl_rel = 1'b0; end
                if (q == 2'd2) begin a.scl_we = 1'b1; a.scl_rel = 1'b1; end
                if (q == 2'd1) begin
                    a.sda_we  = 1'b1;
                    a.sda_rel = (kind == K_WBIT || kind == K_SACK) ? dbit : 1'b1;
                end
                if (kind == K_PULSE && q == 2'd0) begin
                    a.sda_we = 1'b1; a.sda_rel = 1'b1;
                end
            end
            default: a = '0;
        endcase
        return a;
    endfunction

endpackage

// File: rtl/i2c_bit_tick.sv
module i2c_bit_tick #(
    parameter int unsigned DIV = 250
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    assign tick = run && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || !run || tick) cnt <= '0;
        else                     cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/i2c_bit_sync.sv
module i2c_bit_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] ff;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) ff <= '1;
                else     ff <= d;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) ff <= '1;
                else     ff <= {ff[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = ff[STAGES-1];
endmodule

// File: rtl/i2c_bit_seq.sv
module i2c_bit_seq
    import i2c_bit_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cmd_valid,
    input  logic [2:0] cmd_op,
    input  logic [7:0] cmd_data,
    input  logic       cmd_ack,
    input  logic       tick,
    input  logic       sda_s,
    output logic       cmd_ready,
    output logic       busy,
    output logic       done,
    output logic [7:0] rx_data,
    output logic       rx_nack,
    output logic       scl_rel,
    output logic       sda_rel
);
    logic [2:0]       op_r;
    logic [IDX_W-1:0] idx;
    logic [1:0]       q;
    logic [7:0]       tx_r;
    logic             ack_r;
    logic             accept;
    logic             is_last;
    logic             dbit;
    bit_kind_e        cur_kind;
    line_act_t        act;

    assign cmd_ready = !busy;
    assign accept    = cmd_valid && !busy;
    assign cur_kind  = kind_of(op_r, idx);
    assign is_last   = (idx == last_bit(op_r));
    assign dbit      = (cur_kind == K_SACK) ? ack_r : tx_r[~idx[2:0]];

    always_comb begin
        act = '0;
        if (accept)
            act = act_of(kind_of(cmd_op, '0), 2'd0, 1'b1);
        else if (tick) begin
            if (q != 2'd3)
                act = act_of(cur_kind, q + 2'd1, dbit);
            else if (!is_last)
                act = act_of(kind_of(op_r, idx + 1'b1), 2'd0, 1'b1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            op_r    <= '0;
            idx     <= '0;
            q       <= '0;
            tx_r    <= '0;
            ack_r   <= 1'b0;
            rx_data <= '0;
            rx_nack <= 1'b0;
            scl_rel <= 1'b1;
            sda_rel <= 1'b1;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            if (act.scl_we) scl_rel <= act.scl_rel;
            if (act.sda_we) sda_rel <= act.sda_rel;
            if (accept) begin
                busy  <= 1'b1;
                op_r  <= cmd_op;
                idx   <= '0;
                q     <= '0;
                tx_r  <= cmd_data;
                ack_r <= cmd_ack;
            end else if (tick) begin
                q <= q + 2'd1;
                if (cur_kind == K_RBIT && q == 2'd2)
                    rx_data <= {rx_data[6:0], sda_s};
                if (cur_kind == K_WACK && q == 2'd3)
                    rx_nack <= sda_s;
                if (q == 2'd3) begin
                    if (is_last) begin
                        busy <= 1'b0;
                        done <= 1'b1;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
            end
        end
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!busy && !$past(busy)) |-> ($stable(scl_rel) && $stable(sda_rel))); // R1
    AST_START_FALL_HIGH: assert property (@(posedge clk) disable iff (rst)
        (busy && cur_kind == K_START && $fell(sda_rel)) |-> scl_rel); // R2
    AST_STOP_RISE_HIGH: assert property (@(posedge clk) disable iff (rst)
        (busy && cur_kind == K_STOP && $rose(sda_rel)) |-> scl_rel); // R3
    AST_DATA_MOVES_LOW: assert property (@(posedge clk) disable iff (rst)
        (busy && (cur_kind == K_WBIT || cur_kind == K_SACK) && sda_rel != $past(sda_rel))
        |-> (!scl_rel && !$past(scl_rel))); // R4
    AST_RECOVER_SDA_FREE: assert property (@(posedge clk) disable iff (rst)
        (busy && cur_kind == K_PULSE) |-> sda_rel); // R8
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R9
    AST_BUSY_HOLDS_OP: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(op_r)); // R10
endmodule

// File: rtl/i2c_bit_master.sv
module i2c_bit_master #(
    parameter int unsigned DIV         = 250,
    parameter int          SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cmd_valid,
    output logic       cmd_ready,
    input  logic [2:0] cmd_op,
    input  logic [7:0] cmd_data,
    input  logic       cmd_ack,
    output logic       done,
    output logic [7:0] rx_data,
    output logic       rx_nack,
    input  logic       sda_in,
    output logic       scl_oe,
    output logic       sda_oe
);
    logic busy;
    logic tick;
    logic sda_s;
    logic scl_rel;
    logic sda_rel;

    i2c_bit_tick #(.DIV(DIV)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .run  (busy),
        .tick (tick)
    );

    i2c_bit_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (sda_in),
        .q   (sda_s)
    );

    i2c_bit_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_data  (cmd_data),
        .cmd_ack   (cmd_ack),
        .tick      (tick),
        .sda_s     (sda_s),
        .cmd_ready (cmd_ready),
        .busy      (busy),
        .done      (done),
        .rx_data   (rx_data),
        .rx_nack   (rx_nack),
        .scl_rel   (scl_rel),
        .sda_rel   (sda_rel)
    );

    assign scl_oe = !scl_rel;
    assign sda_oe = !sda_rel;
endmodule

// File: tb/i2c_bit_master_tb.sv
module i2c_bit_master_tb;
    localparam int DIV = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cmd_valid = 1'b0;
    logic [2:0] cmd_op = '0;
    logic [7:0] cmd_data = '0;
    logic       cmd_ack = 1'b0;
    logic       cmd_ready, done, rx_nack, scl_oe, sda_oe;
    logic [7:0] rx_data;
    logic       sda_in;
    logic       slv_sda = 1'b1;

    always #5 clk = ~clk;

    wire scl_line = ~scl_oe;
    assign sda_in = sda_oe ? 1'b0 : slv_sda;

    i2c_bit_master #(.DIV(DIV)) u_dut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_data(cmd_data), .cmd_ack(cmd_ack), .done(done),
        .rx_data(rx_data), .rx_nack(rx_nack), .sda_in(sda_in),
        .scl_oe(scl_oe), .sda_oe(sda_oe)
    );

    typedef struct {
        bit    scl;
        bit    sda;
        bit    dn;
        bit    rdy;
        string req;
    } exp_t;

    exp_t q_exp[$];
    bit   m_scl = 1'b1;
    bit   m_sda = 1'b1;
    int   checks = 0;
    int   fails = 0;
    bit   run_chk = 1'b0;
    bit   finished = 1'b0;

    // Slave model: counts clock-line falls since the command was issued.
    int       fall_cnt = 0;
    int       fall_base = 0;
    int       slv_mode = 0;   // 0 idle, 1 write ack, 2 read data
    bit       slv_ack = 1'b0;
    bit [7:0] slv_byte = '0;

    always @(negedge scl_line) begin
        int k;
        fall_cnt = fall_cnt + 1;
        k = fall_cnt - fall_base;
        if (slv_mode == 1)      slv_sda = (k == 9) ? slv_ack : 1'b1;
        else if (slv_mode == 2) slv_sda = (k >= 1 && k <= 8) ? slv_byte[8-k] : 1'b1;
        else                    slv_sda = 1'b1;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    task automatic quarter(input int s, input int d, input string req);
        if (s >= 0) m_scl = s[0];
        if (d >= 0) m_sda = d[0];
        for (int i = 0; i < DIV; i++) q_exp.push_back('{m_scl, m_sda, 1'b0, 1'b0, req});
    endtask

    task automatic model_stop(input string req);
        quarter(0, -1, req); quarter(-1, 0, req); quarter(1, -1, req); quarter(-1, 1, req);
    endtask

    task automatic model_cmd(input int op, input bit [7:0] data, input bit ack);
        case (op)
            0: begin
                quarter(-1, -1, "R2"); quarter(-1, 1, "R2");
                quarter(1, -1, "R2");  quarter(-1, 0, "R2");
            end
            1: model_stop("R3");
            2: begin
                for (int i = 7; i >= 0; i--) begin
                    quarter(0, -1, "R4"); quarter(-1, int'(data[i]), "R4");
                    quarter(1, -1, "R4"); quarter(-1, -1, "R4");
                end
                quarter(0, -1, "R5"); quarter(-1, 1, "R5");
                quarter(1, -1, "R5"); quarter(-1, -1, "R5");
            end
            3: begin
                for (int i = 0; i < 8; i++) begin
                    quarter(0, -1, "R6"); quarter(-1, 1, "R6");
                    quarter(1, -1, "R6"); quarter(-1, -1, "R6");
                end
                quarter(0, -1, "R7"); quarter(-1, int'(ack), "R7");
                quarter(1, -1, "R7"); quarter(-1, -1, "R7");
            end
            4: begin
                for (int i = 0; i < 9; i++) begin
                    quarter(0, 1, "R8"); quarter(-1, 1, "R8");
                    quarter(1, -1, "R8"); quarter(-1, -1, "R8");
                end
                model_stop("R8");
            end
            default: for (int i = 0; i < 4; i++) quarter(-1, -1, "R11");
        endcase
        q_exp.push_back('{m_scl, m_sda, 1'b1, 1'b1, "R9"});
    endtask

    // Cycle-by-cycle comparison against the model.
    always @(negedge clk) begin
        if (run_chk && !finished) begin
            exp_t e;
            if (q_exp.size() > 0) e = q_exp.pop_front();
            else                  e = '{m_scl, m_sda, 1'b0, 1'b1, "R1"};
            check((scl_oe == !e.scl) && (sda_oe == !e.sda) && (done == e.dn) && (cmd_ready == e.rdy),
                  e.req, "lines{scl_oe,sda_oe,done,ready}",
                  int'({scl_oe, sda_oe, done, cmd_ready}),
                  int'({!e.scl, !e.sda, e.dn, e.rdy}));
        end
    end

    task automatic issue(input int op, input bit [7:0] data, input bit ack,
                         input bit [7:0] sbyte, input bit sack, input bit poke);
        @(negedge clk);
        fall_base = fall_cnt;
        slv_mode  = (op == 2) ? 1 : (op == 3) ? 2 : 0;
        slv_byte  = sbyte;
        slv_ack   = sack;
        cmd_valid = 1'b1;
        cmd_op    = op[2:0];
        cmd_data  = data;
        cmd_ack   = ack;
        @(posedge clk);
        #1;
        cmd_valid = 1'b0;
        model_cmd(op, data, ack);
        if (poke) begin
            repeat (2) @(negedge clk);
            cmd_valid = 1'b1;
            cmd_op    = 3'd4;
            cmd_data  = 8'hFF;
            repeat (3) @(negedge clk);
            check(cmd_ready == 1'b0, "R10", "ready while busy", int'(cmd_ready), 0);
            cmd_valid = 1'b0;
        end
        wait (q_exp.size() == 0);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1;
        rst = 1'b0;
        @(negedge clk);
        check(scl_oe == 1'b0 && sda_oe == 1'b0, "R1", "lines after reset",
              int'({scl_oe, sda_oe}), 0);
        check(cmd_ready == 1'b1 && done == 1'b0, "R1", "ready/done after reset",
              int'({cmd_ready, done}), 2);
        run_chk = 1'b1;
        repeat (3) @(negedge clk);

        issue(4, 8'h00, 1'b0, 8'h00, 1'b0, 1'b0);             // R8
        issue(0, 8'h00, 1'b0, 8'h00, 1'b0, 1'b1);             // R2, R10
        issue(2, 8'hA5, 1'b0, 8'h00, 1'b0, 1'b0);             // R4
        check(rx_nack == 1'b0, "R5", "ack level after write", int'(rx_nack), 0);
        issue(2, 8'h3C, 1'b0, 8'h00, 1'b1, 1'b1);             // R5, R10
        check(rx_nack == 1'b1, "R5", "nack level after write", int'(rx_nack), 1);
        issue(0, 8'h00, 1'b0, 8'h00, 1'b0, 1'b0);             // repeated start
        issue(3, 8'h00, 1'b0, 8'hC3, 1'b0, 1'b0);             // R6, R7
        check(rx_data == 8'hC3, "R6", "read byte", int'(rx_data), 'hC3);
        issue(3, 8'h00, 1'b1, 8'h1E, 1'b0, 1'b1);             // R6, R7, R10
        check(rx_data == 8'h1E, "R6", "read byte after busy poke", int'(rx_data), 'h1E);
        issue(1, 8'h00, 1'b0, 8'h00, 1'b0, 1'b0);             // R3
        issue(7, 8'h55, 1'b0, 8'h00, 1'b0, 1'b0);             // R11
        check(rx_data == 8'h1E && rx_nack == 1'b1, "R11", "results kept by no-op",
              int'({rx_nack, rx_data}), 'h11E);
        issue(2, 8'h00, 1'b0, 8'h00, 1'b0, 1'b0);             // R4 all-zero byte
        check(rx_nack == 1'b0, "R5", "ack after zero byte", int'(rx_nack), 0);
        issue(3, 8'h00, 1'b1, 8'hFF, 1'b0, 1'b0);             // R6 all-ones byte
        check(rx_data == 8'hFF, "R6", "read all ones", int'(rx_data), 'hFF);
        issue(1, 8'h00, 1'b0, 8'h00, 1'b0, 1'b0);
        repeat (6) @(negedge clk);

        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            fails++;
            $display("FAIL R9 watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule